// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits on a 24-bit CPU address bus and turns each qualified bus access into one chip select. The targets are RAM, ROM, a SCSI controller, a serial controller, a floppy controller and a parallel interface adapter. The serial controller has a window for reads and a separate window for writes. Only the five most significant address bits take part in the decode, so each window is a multiple of 512 KiB. Unmapped guard zones sit between the peripheral windows, and an access to one of them raises an invalid-access flag. The selects and the flag are combinational and are valid only while the address-valid strobe is high.

At power-up the CPU fetches its reset vectors from address zero. To make this work, the decoder holds a boot overlay flag that reset sets. While the flag is set, the low 4 MiB maps to ROM, and the window at 0x600000 maps to RAM. The decoder watches the bus and clears the flag on the first valid access to the normal ROM window at 0x400000, or on the first valid write to the low RAM area. The flag then stays clear until the next reset, and the low area becomes RAM.

Top module: `boot_map_decoder`

## Requirements
- R1: The decode depends only on address bits 23..19. Accesses that differ only in bits 18..0 give identical outputs.
- R2: Addresses 0x000000–0x3FFFFF assert `sel_rom` while the overlay is set and `sel_ram` while it is clear.
- R3: Addresses 0x400000–0x4FFFFF assert `sel_rom` whatever the state of the overlay.
- R4: Addresses 0x580000–0x5FFFFF assert `sel_scsi`.
- R5: Addresses 0x600000–0x6FFFFF assert `sel_ram` while the overlay is set and `bad_access` while it is clear.
- R6: A read (`wr`=0) at 0x900000–0x9FFFFF asserts `sel_ser_rd`. A write (`wr`=1) at 0xB00000–0xBFFFFF asserts `sel_ser_wr`. An access in either window with the other direction asserts `bad_access`.
- R7: Addresses 0xD00000–0xDFFFFF assert `sel_flop`, and addresses 0xE80000–0xEFFFFF assert `sel_pia`.
- R8: The guard zones 0x500000–0x57FFFF, 0x700000–0x8FFFFF, 0xA00000–0xAFFFFF, 0xC00000–0xCFFFFF and 0xE00000–0xE7FFFF assert `bad_access`.
- R9: Addresses 0xF00000–0xFFFFFF pass through: no select is asserted and `bad_access` stays low.
- R10: Reset sets the overlay. A valid access of either direction to 0x400000–0x4FFFFF clears it at the next rising clock edge. The access that clears the flag still decodes with the old value.
- R11: A valid write to 0x000000–0x3FFFFF clears the overlay at the next rising edge. Reads in that area leave it set.
- R12: Once clear, the overlay stays clear until reset.
- R13: While `as_valid` is low, every output is low and the overlay does not change.
- R14: At most one of the seven selects and `bad_access` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the overlay flag updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay |
| addr | input | 24 | CPU address |
| wr | input | 1 | 1 = write, 0 = read |
| as_valid | input | 1 | Address-valid strobe; qualifies the decode |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_scsi | output | 1 | SCSI controller select |
| sel_ser_rd | output | 1 | Serial controller read select |
| sel_ser_wr | output | 1 | Serial controller write select |
| sel_flop | output | 1 | Floppy controller select |
| sel_pia | output | 1 | Parallel interface adapter select |
| bad_access | output | 1 | Access to a guard zone, an undecoded window, or a serial window with the wrong direction |

## Verification
The bench targets the overlay transitions, which are the likeliest place for an error:
- A read to the low area must not clear the flag; a design that cleared it there would hand RAM to a boot vector fetch.
- An access with the strobe low must not clear the flag either.
- The clearing access must still see ROM; a design that decoded it with the new value would deselect the ROM too early.

Window edges are probed at their first and last byte. The boundaries 0x57FFFF/0x580000 and 0xE7FFFF/0xE80000 show whether a design compares more address bits than bits 23..19 or fewer. The serial windows are hit in both directions, to catch a design that ignores `wr`. The 0xF00000 zone and 0x600000 after the flag clears separate a pass-through from an invalid access.

// File: rtl/boot_map_decoder.sv
module boot_map_decoder #(
  parameter int ADDR_W = 24,
  parameter int ZONE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              as_valid,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_scsi,
  output logic              sel_ser_rd,
  output logic              sel_ser_wr,
  output logic              sel_flop,
  output logic              sel_pia,
  output logic              bad_access
);

  localparam logic [ZONE_W-1:0] Z_ROM_HI  = ZONE_W'(9);
  localparam logic [ZONE_W-1:0] Z_ROM_LO  = ZONE_W'(8);
  localparam logic [ZONE_W-1:0] Z_SCSI    = ZONE_W'(11);
  localparam logic [ZONE_W-1:0] Z_BOOTRAM = ZONE_W'(12);
  localparam logic [ZONE_W-1:0] Z_SRD     = ZONE_W'(18);
  localparam logic [ZONE_W-1:0] Z_SWR     = ZONE_W'(22);
  localparam logic [ZONE_W-1:0] Z_FLOP    = ZONE_W'(26);
  localparam logic [ZONE_W-1:0] Z_PIA     = ZONE_W'(29);
  localparam logic [ZONE_W-1:0] Z_TOP     = ZONE_W'(30);

  logic [ZONE_W-1:0] zone;
  logic [7:0]        dec;
  logic              ovl;
  logic              ovl_clr;

  assign zone = addr[ADDR_W-1 -: ZONE_W];

  // dec = {ram, rom, scsi, ser_rd, ser_wr, flop, pia, bad}
  always_comb begin
    dec = 8'b0;
    if (zone < Z_ROM_LO)                          dec = ovl ? 8'b0100_0000 : 8'b1000_0000;
    else if (zone <= Z_ROM_HI)                    dec = 8'b0100_0000;
    else if (zone == Z_SCSI)                      dec = 8'b0010_0000;
    else if (zone == Z_BOOTRAM || zone == Z_BOOTRAM + 1'b1)
                                                  dec = ovl ? 8'b1000_0000 : 8'b0000_0001;
    else if (zone == Z_SRD || zone == Z_SRD + 1'b1)
                                                  dec = wr ? 8'b0000_0001 : 8'b0001_0000;
    else if (zone == Z_SWR || zone == Z_SWR + 1'b1)
                                                  dec = wr ? 8'b0000_1000 : 8'b0000_0001;
    else if (zone == Z_FLOP || zone == Z_FLOP + 1'b1)
                                                  dec = 8'b0000_0100;
    else if (zone == Z_PIA)                       dec = 8'b0000_0010;
    else if (zone >= Z_TOP)                       dec = 8'b0;
    else                                          dec = 8'b0000_0001;
    if (!as_valid) dec = 8'b0;
  end

  assign {sel_ram, sel_rom, sel_scsi, sel_ser_rd, sel_ser_wr, sel_flop, sel_pia, bad_access} = dec;

  assign ovl_clr = as_valid && ((zone >= Z_ROM_LO && zone <= Z_ROM_HI) || (wr && zone < Z_ROM_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovl <= 1'b1;
    else if (ovl_clr) ovl <= 1'b0;
  end

  // R14
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram, sel_rom, sel_scsi, sel_ser_rd, sel_ser_wr, sel_flop, sel_pia, bad_access}));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_valid |-> !(sel_ram || sel_rom || sel_scsi || sel_ser_rd || sel_ser_wr || sel_flop || sel_pia || bad_access));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_valid |=> $stable(ovl));

  // R6
  ser_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ser_rd |-> !wr) and (sel_ser_wr |-> wr));

  // R10
  rom_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_valid && addr[ADDR_W-1 -: 4] == 4'h4) |=> !(sel_rom && addr[ADDR_W-1 -: 2] == 2'b00));

  // R11
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_valid && wr && addr[ADDR_W-1 -: 2] == 2'b00) |=> !(sel_rom && addr[ADDR_W-1 -: 2] == 2'b00));

  // R12
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl |=> !ovl);

endmodule

// File: tb/test_boot_map_decoder.sv
module test_boot_map_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic        as_valid = 1'b0;
  logic sel_ram, sel_rom, sel_scsi, sel_ser_rd, sel_ser_wr, sel_flop, sel_pia, bad_access;

  int checks = 0;
  int errors = 0;
  bit model_ovl = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_map_decoder i_boot_map_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .as_valid(as_valid),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_scsi(sel_scsi), .sel_ser_rd(sel_ser_rd),
    .sel_ser_wr(sel_ser_wr), .sel_flop(sel_flop), .sel_pia(sel_pia), .bad_access(bad_access)
  );

  // {ram, rom, scsi, ser_rd, ser_wr, flop, pia, bad}
  function automatic logic [7:0] expect_sel(logic [23:0] a, logic w, logic v, bit o);
    logic [7:0] e;
    if (!v) return 8'h00;
    if (a <= 24'h3FFFFF)                          e = o ? 8'h40 : 8'h80;
    else if (a <= 24'h4FFFFF)                     e = 8'h40;
    else if (a <= 24'h57FFFF)                     e = 8'h01;
    else if (a <= 24'h5FFFFF)                     e = 8'h20;
    else if (a <= 24'h6FFFFF)                     e = o ? 8'h80 : 8'h01;
    else if (a <= 24'h8FFFFF)                     e = 8'h01;
    else if (a <= 24'h9FFFFF)                     e = w ? 8'h01 : 8'h10;
    else if (a <= 24'hAFFFFF)                     e = 8'h01;
    else if (a <= 24'hBFFFFF)                     e = w ? 8'h08 : 8'h01;
    else if (a <= 24'hCFFFFF)                     e = 8'h01;
    else if (a <= 24'hDFFFFF)                     e = 8'h04;
    else if (a <= 24'hE7FFFF)                     e = 8'h01;
    else if (a <= 24'hEFFFFF)                     e = 8'h02;
    else                                          e = 8'h00;
    return e;
  endfunction

  function automatic string req_of(logic [23:0] a, logic v);
    if (!v) return "R13";
    if (a <= 24'h3FFFFF) return "R2";
    if (a <= 24'h4FFFFF) return "R3";
    if (a >= 24'h580000 && a <= 24'h5FFFFF) return "R4";
    if (a >= 24'h600000 && a <= 24'h6FFFFF) return "R5";
    if ((a >= 24'h900000 && a <= 24'h9FFFFF) || (a >= 24'hB00000 && a <= 24'hBFFFFF)) return "R6";
    if ((a >= 24'hD00000 && a <= 24'hDFFFFF) || a >= 24'hE80000 && a <= 24'hEFFFFF) return "R7";
    if (a >= 24'hF00000) return "R9";
    return "R8";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    as_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_ovl = 1'b1;
  endtask

  task automatic access(logic [23:0] a, logic w, logic v, string tag);
    logic [7:0] got, exp;
    @(negedge clk);
    addr = a; wr = w; as_valid = v;
    #1;
    got = {sel_ram, sel_rom, sel_scsi, sel_ser_rd, sel_ser_wr, sel_flop, sel_pia, bad_access};
    exp = expect_sel(a, w, v, model_ovl);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%06h wr=%0b v=%0b actual=%08b expected=%08b", tag, a, w, v, got, exp);
    end
    if (v && ((a >= 24'h400000 && a <= 24'h4FFFFF) || (w && a <= 24'h3FFFFF))) model_ovl = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] ra;
    do_reset();
    access(24'h000000, 1'b0, 1'b0, "R13 idle after reset");
    access(24'h000000, 1'b0, 1'b1, "R2 reset state boot ROM");
    access(24'h3FFFFF, 1'b0, 1'b1, "R11 read keeps overlay");
    access(24'h400000, 1'b0, 1'b0, "R13 idle no clear");
    access(24'h000004, 1'b0, 1'b1, "R13 overlay still set");
    access(24'h650000, 1'b1, 1'b1, "R5 boot RAM");
    access(24'h57FFFF, 1'b0, 1'b1, "R8 guard edge");
    access(24'h580000, 1'b0, 1'b1, "R4 scsi edge");
    access(24'h123456, 1'b1, 1'b1, "R11 clearing write sees ROM");
    access(24'h123456, 1'b0, 1'b1, "R11 now RAM");
    access(24'h600000, 1'b0, 1'b1, "R5 undecoded after clear");
    access(24'h4ABCDE, 1'b0, 1'b1, "R3 ROM after clear");
    access(24'h000000, 1'b0, 1'b1, "R12 stays clear");
    do_reset();
    access(24'h4FFFFF, 1'b1, 1'b1, "R10 clearing access sees ROM");
    access(24'h000000, 1'b0, 1'b1, "R10 cleared by ROM access");
    access(24'h900000, 1'b1, 1'b1, "R6 write in read window");
    access(24'h9FFFFF, 1'b0, 1'b1, "R6 read window");
    access(24'hB00000, 1'b0, 1'b1, "R6 read in write window");
    access(24'hBFFFFF, 1'b1, 1'b1, "R6 write window");
    access(24'hE7FFFF, 1'b0, 1'b1, "R8 guard below PIA");
    access(24'hE80000, 1'b0, 1'b1, "R7 PIA edge");
    access(24'hD7FFFF, 1'b1, 1'b1, "R7 floppy");
    access(24'hFFFFF0, 1'b0, 1'b1, "R9 autovector pass-through");
    access(24'hF00000, 1'b1, 1'b1, "R9 top zone");
    access(24'hA40000, 1'b0, 1'b1, "R8 guard A");
    access(24'h5BFFFF, 1'b0, 1'b1, "R1 low bits ignored");
    access(24'h580001, 1'b0, 1'b1, "R1 low bits ignored");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0) do_reset();
      ra = 24'($urandom);
      access(ra, 1'($urandom), ($urandom % 4) != 0, req_of(ra, 1'b1));
    end

    // R14 is covered by every check comparing all eight outputs as one word.
    finish_run();
  end
endmodule